// File: doc/BRIEF.md
# Multiply-Accumulate Sequencer with Delay-Line Shift

This block computes the sum of N products taken pairwise from two word arrays held in a synchronous memory. One array is the sample array (called A) and the other is the coefficient array (called B). A start pulse gives the element count, the two base pointers and the operand mode. The block then reads each pair from memory, multiplies it and adds it into a 32-bit accumulator. When the run ends, it returns the sum as a low and a high half, returns both pointers advanced by N, and raises `done` for one cycle.

A persistent delay-line mode is set by one control pulse and cleared by another. When the mode is on, an extra pass follows the accumulation. This pass rewrites the sample array in place so that each sample moves one slot forward and the oldest sample is dropped. This advances an FIR filter by one time step with no software help.

The controller is a state machine with these states:
- ST_IDLE: waits for `start`.
- ST_RD_A and ST_RD_B: issue the two reads of one element.
- ST_ACC: adds the product.
- ST_F_RD and ST_F_WR: read one sample and write it one slot higher.
- ST_FINISH: raises `done`.

The transitions are:
- IDLE to RD_A on a start with N above zero, or IDLE to FINISH on a start with N of zero.
- RD_A to RD_B, and RD_B to ACC.
- ACC back to RD_A while elements remain.
- ACC to F_RD after the last element when the mode is on and N is at least 2, otherwise ACC to FINISH.
- F_RD to F_WR.
- F_WR back to F_RD while slots remain, otherwise F_WR to FINISH.
- FINISH to IDLE.

Top module: `mac_seq`

## Requirements
- R1: With `mode_mixed`=0, both array words are two's complement. The result is the sum of A[i]*B[i] for i in 0..N-1, reduced modulo 2^32, with bits 15:0 on `result_lo` and bits 31:16 on `result_hi`. The accumulator starts from zero at each accepted start.
- R2: With `mode_mixed`=1, each A word is taken as unsigned and each B word as two's complement. The result is otherwise formed as in R1.
- R3: When `done` is high, `ptr_a_out` and `ptr_b_out` equal the start values of `ptr_a` and `ptr_b` plus N, modulo 2^AW.
- R4: With the delay-line mode on at start and N of at least 2, the memory afterwards holds the old A[i] at slot i+1 for i in 0..N-2. Old A[N-1] is lost, A[0] keeps its value and is never written, and the B array is unchanged. With the mode off, memory is unchanged.
- R5: A `fir_set` pulse turns the delay-line mode on and a `fir_clr` pulse turns it off. When both are high, off wins. The mode is off after reset and keeps its value between pulses. Each run uses the mode value at its start pulse.
- R6: A start with N=0 makes no memory access and raises `done` in the next cycle with a zero result.
- R7: `done` is high for exactly one cycle per run. The result and pointer outputs hold until the next accepted start.
- R8: A start pulse while a run is in progress is ignored.
- R9: The memory port makes at most one access per cycle and never reads and writes in the same cycle. Read data is taken one cycle after the read is issued.
- R10: After reset, `done`, `result_lo`, `result_hi`, `ptr_a_out` and `ptr_b_out` are zero, and `mem_re` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| count | input | NW | Number of element pairs N |
| ptr_a | input | AW | Base address of sample array A |
| ptr_b | input | AW | Base address of coefficient array B |
| mode_mixed | input | 1 | 0: signed x signed, 1: unsigned A x signed B |
| fir_set | input | 1 | Turn delay-line mode on |
| fir_clr | input | 1 | Turn delay-line mode off (wins over set) |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after the read |
| result_lo | output | DW | Low half of the sum |
| result_hi | output | ACCW-DW | High half of the sum |
| ptr_a_out | output | AW | Advanced pointer A |
| ptr_b_out | output | AW | Advanced pointer B |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with AW=8 and NW=4, using a 256-word memory model. The 8-bit pointers let a run starting at 0xFC wrap past the top of memory, so address and pointer wrap are checked together with the delay-line rewrite across the wrap. The bench sweeps every N from 0 to 7 in both operand modes, with the delay-line mode both on and off. The data mixes 0x8000, 0xFFFF and scattered words, so sign handling and the 2^32 wrap of the sum are compared against sums computed in the bench.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_ACC,
        ST_F_RD,
        ST_F_WR,
        ST_FINISH
    } mac_state_t;
endpackage

// File: rtl/mac_prod.sv
module mac_prod #(
    parameter int DW   = 16,
    parameter int ACCW = 32
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic            mixed_i,
    output logic [ACCW-1:0] prod_o
);
    logic signed [ACCW-1:0] ext_a;
    logic signed [ACCW-1:0] ext_b;
    logic signed [ACCW-1:0] prod_s;

    // A is zero-extended in mixed mode, sign-extended otherwise; B is always signed
    assign ext_a  = mixed_i ? $signed(ACCW'(a_i)) : ACCW'($signed(a_i));
    assign ext_b  = ACCW'($signed(b_i));
    assign prod_s = ext_a * ext_b;
    assign prod_o = $unsigned(prod_s);
endmodule

// File: rtl/mac_fir_mode.sv
module mac_fir_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic mode_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_o <= 1'b0;
        else if (clr_i)
            mode_o <= 1'b0;
        else if (set_i)
            mode_o <= 1'b1;
    end

    // R5
    fir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !mode_o);
    // R5
    fir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> mode_o);
endmodule

// File: rtl/mac_seq.sv
module mac_seq
    import mac_seq_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int NW   = 8,
    parameter int ACCW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NW-1:0]      count,
    input  logic [AW-1:0]      ptr_a,
    input  logic [AW-1:0]      ptr_b,
    input  logic               mode_mixed,
    input  logic               fir_set,
    input  logic               fir_clr,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    output logic [DW-1:0]      result_lo,
    output logic [ACCW-DW-1:0] result_hi,
    output logic [AW-1:0]      ptr_a_out,
    output logic [AW-1:0]      ptr_b_out,
    output logic               done
);
    localparam logic [NW-1:0] ONE_N = NW'(1);

    mac_state_t       st, st_nx;
    logic [AW-1:0]    base_a, base_b;
    logic [NW-1:0]    n_q, idx;
    logic             mixed_q, fir_q, fir_mode;
    logic [DW-1:0]    opa_q;
    logic [ACCW-1:0]  acc_q, prod;
    logic             last_elem;

    mac_fir_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fir_set),
        .clr_i  (fir_clr),
        .mode_o (fir_mode)
    );

    mac_prod #(.DW(DW), .ACCW(ACCW)) u_prod (
        .a_i     (opa_q),
        .b_i     (mem_rdata),
        .mixed_i (mixed_q),
        .prod_o  (prod)
    );

    assign last_elem = (idx == n_q - ONE_N);

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = (count == '0) ? ST_FINISH : ST_RD_A;
            ST_RD_A:   st_nx = ST_RD_B;
            ST_RD_B:   st_nx = ST_ACC;
            ST_ACC: begin
                if (!last_elem)
                    st_nx = ST_RD_A;
                else if (fir_q && n_q > ONE_N)
                    st_nx = ST_F_RD;
                else
                    st_nx = ST_FINISH;
            end
            ST_F_RD:   st_nx = ST_F_WR;
            ST_F_WR:   st_nx = (idx == ONE_N) ? ST_FINISH : ST_F_RD;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = mem_rdata;
        done      = 1'b0;
        unique case (st)
            ST_RD_A: begin
                mem_addr = base_a + AW'(idx);
                mem_re   = 1'b1;
            end
            ST_RD_B: begin
                mem_addr = base_b + AW'(idx);
                mem_re   = 1'b1;
            end
            ST_F_RD: begin
                mem_addr = base_a + AW'(idx) - AW'(1);
                mem_re   = 1'b1;
            end
            ST_F_WR: begin
                mem_addr = base_a + AW'(idx);
                mem_we   = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_a    <= '0;
            base_b    <= '0;
            n_q       <= '0;
            idx       <= '0;
            mixed_q   <= 1'b0;
            fir_q     <= 1'b0;
            opa_q     <= '0;
            acc_q     <= '0;
            ptr_a_out <= '0;
            ptr_b_out <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    base_a    <= ptr_a;
                    base_b    <= ptr_b;
                    n_q       <= count;
                    idx       <= '0;
                    mixed_q   <= mode_mixed;
                    fir_q     <= fir_mode;
                    acc_q     <= '0;
                    ptr_a_out <= ptr_a + AW'(count);
                    ptr_b_out <= ptr_b + AW'(count);
                end
                ST_RD_B: opa_q <= mem_rdata;
                ST_ACC: begin
                    acc_q <= acc_q + prod;
                    idx   <= last_elem ? n_q - ONE_N : idx + ONE_N;
                end
                ST_F_WR: idx <= idx - ONE_N;
                default: ;
            endcase
        end
    end

    assign result_lo = acc_q[DW-1:0];
    assign result_hi = acc_q[ACCW-1:DW];

    // R7
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && count == '0) |=> (done && !mem_re && !mem_we));
    // R4
    keep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr != base_a));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(base_a) && $stable(n_q) && $stable(ptr_a_out)));
endmodule

// File: tb/tb_mac_seq.sv
module tb_mac_seq;
    localparam int DW = 16, AW = 8, NW = 4, ACCW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NW-1:0] count = '0;
    logic [AW-1:0] ptr_a = '0, ptr_b = '0;
    logic mode_mixed = 1'b0, fir_set = 1'b0, fir_clr = 1'b0;
    logic [AW-1:0] mem_addr;
    logic mem_re, mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] result_lo;
    logic [ACCW-DW-1:0] result_hi;
    logic [AW-1:0] ptr_a_out, ptr_b_out;
    logic done;

    logic tb_we = 1'b0;
    logic [AW-1:0] tb_addr = '0;
    logic [DW-1:0] tb_data = '0;
    logic [DW-1:0] mem [256];

    int n_tests = 0;
    int n_fail = 0;
    int excl_viol = 0;

    always #5 clk = ~clk;

    mac_seq #(.DW(DW), .AW(AW), .NW(NW), .ACCW(ACCW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .ptr_a(ptr_a), .ptr_b(ptr_b), .mode_mixed(mode_mixed),
        .fir_set(fir_set), .fir_clr(fir_clr),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .result_lo(result_lo), .result_hi(result_hi),
        .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out), .done(done)
    );

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else if (tb_we) mem[tb_addr] <= tb_data;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (rst_n && mem_re && mem_we) excl_viol <= excl_viol + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] gen(input int seed, input int i);
        if ((seed + i) % 5 == 0) return 16'h8000;
        if ((seed + i) % 5 == 1) return 16'hFFFF;
        return 16'(seed * 40503 + i * 9973 + 17);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic pulse_mode(input bit s, input bit c);
        fir_set = s; fir_clr = c;
        @(negedge clk);
        fir_set = 1'b0; fir_clr = 1'b0;
    endtask

    // Run one operation; mode_exp is the delay-line mode the bench expects at start.
    // busy_n: if nonzero, a spurious start with this count is pulsed mid-run (R8).
    task automatic run_op(input int n, input logic [AW-1:0] pa, input logic [AW-1:0] pb,
                          input bit mx, input bit mode_exp, input int seed,
                          input int busy_n, input bit set_mid);
        logic [DW-1:0] a_old [16];
        logic [DW-1:0] b_old [16];
        longint sum = 0;
        logic [31:0] exp32;
        int cyc = 0;
        int bad = 0;
        bit got = 0;
        for (int i = 0; i < 16; i++) begin
            a_old[i] = gen(seed, i);
            b_old[i] = gen(seed + 3, i + 11);
        end
        for (int i = 0; i < n; i++) begin
            wr(pa + AW'(i), a_old[i]);
            wr(pb + AW'(i), b_old[i]);
        end
        for (int i = 0; i < n; i++) begin
            if (mx) sum += longint'(a_old[i]) * longint'($signed(b_old[i]));
            else    sum += longint'($signed(a_old[i])) * longint'($signed(b_old[i]));
        end
        exp32 = sum[31:0];
        start = 1'b1; count = NW'(n); ptr_a = pa; ptr_b = pb; mode_mixed = mx;
        while (cyc < 500) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc == 3 && busy_n != 0) begin
                start = 1'b1; count = NW'(busy_n); ptr_a = pb; ptr_b = pa; mode_mixed = ~mx;
            end
            if (cyc == 4 && set_mid) pulse_mode(1'b1, 1'b0);
            if (done) begin got = 1; break; end
        end
        start = 1'b0;
        chk(got, "R7 done seen", got, 1);
        if (n == 0) chk(cyc == 1, "R6 zero-count latency", cyc, 1);
        chk({result_hi, result_lo} == exp32, mx ? "R2 mixed sum" : "R1 signed sum",
            {result_hi, result_lo}, exp32);
        chk(ptr_a_out == pa + AW'(n), "R3 ptr_a advance", ptr_a_out, pa + AW'(n));
        chk(ptr_b_out == pb + AW'(n), "R3 ptr_b advance", ptr_b_out, pb + AW'(n));
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] ea;
            ea = (mode_exp && i > 0) ? a_old[i-1] : a_old[i];
            if (mem[pa + AW'(i)] != ea) bad++;
            if (mem[pb + AW'(i)] != b_old[i]) bad++;
        end
        chk(bad == 0, mode_exp ? "R4 delay-line rewrite" : "R4 memory unchanged", bad, 0);
        @(negedge clk);
        chk(!done, "R7 done single cycle", done, 0);
        chk({result_hi, result_lo} == exp32, "R7 result held", {result_hi, result_lo}, exp32);
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 0 && mem_re == 0 && mem_we == 0, "R10 reset strobes", {done, mem_re, mem_we}, 0);
        chk({result_hi, result_lo} == 0, "R10 reset result", {result_hi, result_lo}, 0);
        chk(ptr_a_out == 0 && ptr_b_out == 0, "R10 reset pointers", {ptr_a_out, ptr_b_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset mode off: a 3-element run must not rewrite memory
        run_op(3, 8'h20, 8'h60, 1'b0, 1'b0, 99, 0, 1'b0);

        for (int f = 0; f < 2; f++) begin
            if (f == 1) pulse_mode(1'b1, 1'b0);
            for (int mx = 0; mx < 2; mx++)
                for (int n = 0; n < 8; n++)
                    run_op(n, 8'h10, 8'h40, mx[0], f[0], n * 7 + mx + f * 31, 0, 1'b0);
            // address and pointer wrap past the top of memory
            run_op(7, 8'hFC, 8'h80, 1'b0, f[0], 55 + f, 0, 1'b0);
        end
        // R5 both controls high: off wins
        pulse_mode(1'b1, 1'b1);
        run_op(4, 8'h30, 8'h70, 1'b1, 1'b0, 77, 0, 1'b0);
        // R8 start while busy ignored; R5 set mid-run applies only to the next run
        run_op(5, 8'h30, 8'h70, 1'b0, 1'b0, 81, 2, 1'b1);
        run_op(5, 8'h30, 8'h70, 1'b0, 1'b1, 82, 0, 1'b0);
        // R5 clear turns the mode off again
        pulse_mode(1'b0, 1'b1);
        run_op(6, 8'h30, 8'h70, 1'b1, 1'b0, 83, 0, 1'b0);

        chk(excl_viol == 0, "R9 read and write exclusive", excl_viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule